// File: doc/BRIEF.md
# Table-Driven Sine Sample Generator

This block produces a continuous stream of 8-bit unsigned sine samples intended for a resistor-ladder digital-to-analog converter. A code of 0x00 corresponds to ground and 0xFF to the full supply, so the waveform is centred on mid-scale. No software control is involved: once reset is released, the samples simply keep flowing.

Internally, a free-running prescaler counts clock cycles. Its terminal-count strobe advances a phase address counter. That address selects an entry in a 256-entry sine table, which is computed at elaboration time, and the selected entry is captured in an output register.

The output frequency is the clock rate divided by (prescaler maximum + 1) × table depth. The defaults give a period of about 1 ms from a 125 MHz clock.

Top module: `sineGen`

## Requirements
- R1: Reset is asynchronous and active high. While it is asserted, the sample output reads 0 immediately, with no clock edge needed, and both counters are forced to 0.
- R2: The output is registered. At the first rising clock edge after reset is released, the sample becomes table entry 0, which is 127 (0x7F).
- R3: The phase address holds each value for exactly PRE_MAX+1 clocks (489 with defaults) and then steps by one. Table entry k therefore appears on the output after rising edge (PRE_MAX+1)·k+1, counted from reset release.
- R4: After the last table address (255), the phase address wraps to 0. One full output period is (PRE_MAX+1)·256 clocks, which is 125,184 with defaults.
- R5: Table entry i holds the value ⌊255·(sin(2πi/256)+1)/2⌋, truncated toward zero. Entry 1 is therefore 130 and entry 255 is 124.
- R6: The output reaches its peak value of 255 only at table index 64. It reads 0 at table index 192.
- R7: The prescaler's terminal count is high exactly while the prescaler is at PRE_MAX. On the next clock the prescaler returns to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, rising-edge active |
| rst | input | 1 | Asynchronous active-high reset |
| sample | output | SAMPLE_W (8) | Registered unsigned sine sample for the DAC |

## Verification
The bench builds the block with its default parameters: a prescaler maximum of 488, an 8-bit address and 8-bit samples. With these values a full 125,184-clock period, and therefore every one of the 256 table entries, is compared cycle by cycle against a reference model computed by the bench. The defaults also make it possible to measure the exact wrap interval and to reach the peak at index 64 and the trough at index 192. Reset is pulsed at randomly chosen instants in the middle of a cycle. This shows that the output clears immediately and that the sequence restarts from entry 0.

// File: rtl/sineGenPkg.sv
package sineGenPkg;

  // Strobes passed from the timing control to the sample datapath
  typedef struct packed {
    logic preTc;       // prescaler sits at its maximum this cycle
    logic addrAdvance; // phase address steps on the coming edge
  } ctrlStrobe_t;

  localparam real TWO_PI_BASE = 3.141592653589793;

  // Offset sine code for table slot idx, truncated toward zero
  function automatic int sineCode(input int idx, input int depth, input int fullScale);
    real ang;
    real frac;
    ang  = TWO_PI_BASE * 2.0 * real'(idx) / real'(depth);
    frac = ($sin(ang) + 1.0) / 2.0;
    return $rtoi(real'(fullScale) * frac);
  endfunction

endpackage

// File: rtl/wrapCounter.sv
module wrapCounter #(
  parameter int W   = 8,
  parameter int MAX = 255
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [W-1:0] count,
  output logic         atMax
);

  localparam logic [W-1:0] LIMIT = W'(MAX);

  // terminal count is decoded without a register stage
  assign atMax = (count == LIMIT);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      count <= '0;
    else if (en) begin
      if (atMax)
        count <= '0;
      else
        count <= count + 1'b1;
    end
  end

endmodule

// File: rtl/sineGenCtrl.sv
module sineGenCtrl
  import sineGenPkg::*;
#(
  parameter int PRE_MAX = 488,
  parameter int PRE_W   = $clog2(PRE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  output logic [PRE_W-1:0] preCount,
  output ctrlStrobe_t      strobes
);

  logic preAtMax;

  wrapCounter #(
    .W  (PRE_W),
    .MAX(PRE_MAX)
  ) u_prescale (
    .clk  (clk),
    .rst  (rst),
    .en   (1'b1),
    .count(preCount),
    .atMax(preAtMax)
  );

  always_comb begin
    strobes.preTc       = preAtMax;
    strobes.addrAdvance = preAtMax;
  end

endmodule

// File: rtl/sineGenPath.sv
module sineGenPath
  import sineGenPkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobe_t         strobes,
  output logic [ADDR_W-1:0]   addr,
  output logic [SAMPLE_W-1:0] sample
);

  localparam int DEPTH      = 2 ** ADDR_W;
  localparam int ADDR_MAX   = DEPTH - 1;
  localparam int FULL_SCALE = (2 ** SAMPLE_W) - 1;

  logic                addrAtMax;
  logic [SAMPLE_W-1:0] sineRom [DEPTH];

  wrapCounter #(
    .W  (ADDR_W),
    .MAX(ADDR_MAX)
  ) u_phase (
    .clk  (clk),
    .rst  (rst),
    .en   (strobes.addrAdvance),
    .count(addr),
    .atMax(addrAtMax)
  );

  // table contents fixed at elaboration, one constant per slot
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_rom
    localparam int CODE = sineCode(gi, DEPTH, FULL_SCALE);
    assign sineRom[gi] = SAMPLE_W'(CODE);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)
      sample <= '0;
    else
      sample <= sineRom[addr];
  end

endmodule

// File: rtl/sineGen.sv
module sineGen
  import sineGenPkg::*;
#(
  parameter int PRE_MAX  = 488,
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  output logic [SAMPLE_W-1:0] sample
);

  localparam int PRE_W = $clog2(PRE_MAX + 1);

  logic [PRE_W-1:0]  preCount;
  logic [ADDR_W-1:0] addr;
  ctrlStrobe_t       strobes;

  sineGenCtrl #(
    .PRE_MAX(PRE_MAX),
    .PRE_W  (PRE_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .preCount(preCount),
    .strobes (strobes)
  );

  sineGenPath #(
    .ADDR_W  (ADDR_W),
    .SAMPLE_W(SAMPLE_W)
  ) u_path (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .addr   (addr),
    .sample (sample)
  );

endmodule

// File: rtl/sineGenChk.sv
module sineGenChk #(
  parameter int PRE_MAX  = 488,
  parameter int ADDR_W   = 8,
  parameter int SAMPLE_W = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic [$clog2(PRE_MAX+1)-1:0] preCount,
  input logic                         preTc,
  input logic [ADDR_W-1:0]            addr,
  input logic [SAMPLE_W-1:0]          sample
);

  localparam int PRE_W = $clog2(PRE_MAX + 1);
  localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

  // R1
  always @(negedge clk) begin
    if (rst) begin
      resetClear_chk: assert (sample == '0 && addr == '0 && preCount == '0)
        else $error("outputs not cleared under reset");
    end
  end

  // R7
  preWrap_chk: assert property (@(posedge clk) disable iff (rst)
    preTc |=> (preCount == '0));

  // R7
  tcTiming_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(preTc) |-> ($past(preCount) == PRE_W'(PRE_MAX - 1)));

  // R3
  addrHold_chk: assert property (@(posedge clk) disable iff (rst)
    !preTc |=> $stable(addr));

  // R3
  addrStep_chk: assert property (@(posedge clk) disable iff (rst)
    (preTc && addr != ADDR_TOP) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

  // R4
  addrWrap_chk: assert property (@(posedge clk) disable iff (rst)
    (preTc && addr == ADDR_TOP) |=> (addr == '0));

endmodule

bind sineGen sineGenChk #(
  .PRE_MAX (PRE_MAX),
  .ADDR_W  (ADDR_W),
  .SAMPLE_W(SAMPLE_W)
) chk (
  .clk     (clk),
  .rst     (rst),
  .preCount(preCount),
  .preTc   (strobes.preTc),
  .addr    (addr),
  .sample  (sample)
);

// File: tb/tb_sineGen.sv
module tb_sineGen;

  localparam int PRE_MAX  = 488;
  localparam int ADDR_W   = 8;
  localparam int SAMPLE_W = 8;
  localparam int DEPTH    = 2 ** ADDR_W;
  localparam int STEP     = PRE_MAX + 1;
  localparam int PERIOD   = STEP * DEPTH;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [SAMPLE_W-1:0] sample;

  int unsigned nTests = 0;
  int unsigned nFail  = 0;
  int          edgeCnt;
  bit          checking = 1'b0;
  bit          wrapSeen = 1'b0;
  int          prevSample = 0;
  int          refTab [DEPTH];

  always #5 clk = ~clk;

  sineGen #(
    .PRE_MAX (PRE_MAX),
    .ADDR_W  (ADDR_W),
    .SAMPLE_W(SAMPLE_W)
  ) dut (
    .clk   (clk),
    .rst   (rst),
    .sample(sample)
  );

  function automatic int refCode(input int i);
    real ang;
    real frac;
    ang  = 3.141592653589793 * 2.0 * real'(i) / real'(DEPTH);
    frac = ($sin(ang) + 1.0) / 2.0;
    return $rtoi(255.0 * frac);
  endfunction

  function automatic int expSample(input int n);
    if (n == 0) return 0;
    return refTab[((n - 1) / STEP) % DEPTH];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d (edge %0d)", req, act, exp, edgeCnt);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
  endtask

  // edges since reset release, mirrors the asynchronous reset
  always @(posedge clk or posedge rst) begin
    if (rst) edgeCnt <= 0;
    else     edgeCnt <= edgeCnt + 1;
  end

  always @(negedge clk) begin
    if (checking && !rst) begin
      // R3 R5: every sample against the reference table
      check(int'(sample) == expSample(edgeCnt), "R3/R5 stream", int'(sample), expSample(edgeCnt));
      if (edgeCnt == 1)
        check(sample == 8'h7F, "R2 first sample", int'(sample), 127);
      if (edgeCnt == STEP)
        check(sample == 8'h7F, "R3 last cycle of slot 0", int'(sample), 127);
      if (edgeCnt == STEP + 1)
        check(sample == 8'd130, "R3 R5 slot 1", int'(sample), 130);
      if (edgeCnt == 64 * STEP + 1)
        check(sample == 8'd255, "R6 peak", int'(sample), 255);
      if (edgeCnt == 63 * STEP + 1)
        check(sample != 8'd255, "R6 peak only at 64", int'(sample), 254);
      if (edgeCnt == 192 * STEP + 1)
        check(sample == 8'd0, "R6 trough", int'(sample), 0);
      if (edgeCnt == 255 * STEP + 1)
        check(sample == 8'd124, "R5 slot 255", int'(sample), 124);
      if (prevSample == 124 && sample == 8'h7F && !wrapSeen) begin
        wrapSeen = 1'b1;
        check(edgeCnt - 1 == PERIOD, "R4 period", edgeCnt - 1, PERIOD);
      end
    end
    prevSample = int'(sample);
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) refTab[i] = refCode(i);

    rst = 1'b1;
    #23;
    check(sample == '0, "R1 reset value", int'(sample), 0);
    @(negedge clk);
    #2 rst = 1'b0;
    checking = 1'b1;

    repeat (PERIOD + 40) @(negedge clk);
    check(wrapSeen, "R4 wrap observed", int'(wrapSeen), 1);

    // random asynchronous reset pulses mid-run
    for (int k = 0; k < 3; k++) begin
      repeat ($urandom_range(1000, 15000)) @(negedge clk);
      #1 rst = 1'b1;
      #1 check(sample == '0, "R1 async clear", int'(sample), 0);
      @(negedge clk);
      #2 rst = 1'b0;
    end

    repeat (2000) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 195000, 0);
    summary();
    $finish;
  end

endmodule